// File: doc/BRIEF.md
# One-Time-Programmable Protection Word Controller

This block holds a small array of one-time-programmable 16-bit words behind a 16-bit command and data write bus, as found beside the main array of a parallel flash part. The array has a lock word, a factory segment and a user segment, each segment holding `SEG_WORDS` words. Programming is a two-write sequence. The first write is a setup command. The second write carries the target word address and the data. Programming can only clear bits, so a stored word becomes the AND of its old value and the new data.

The lock word guards both segments. A zero in bit 0 freezes the factory segment, and that bit is already zero after initialisation. A zero in bit 1 freezes the user segment and the lock word itself. Neither bit can be set to one again. A program attempt that is refused leaves the data as it was and posts sticky error flags in an 8-bit status byte. An attempt is refused when the programming-voltage-low input is high, when the address falls outside the array, or when the target segment is frozen. The read port returns either the addressed word or the status byte, depending on the current read mode.

Top module: `otp_word_ctrl`

## Requirements
- R1: After reset the block is ready and in array read mode. Reads return 0xFFFE at the lock word address `BASE_ADDR` (0x80). Factory word j (j = 0..3, at 0x81+j) reads `FACTORY_SEED` XOR (j × 0x1111). User words (0x85..0x88) read 0xFFFF. Status reads 0x0080.
- R2: The write 0x00C0 followed by a write of address A and data D stores old AND D at A. Bits never change from 0 to 1.
- R3: After the second write of a sequence, `ready` and status bit 7 are 0 for exactly `PROG_CYCLES` cycles. Bus writes made during that time have no effect.
- R4: A program to the factory segment while lock bit 0 is 0 leaves the word unchanged and sets status bit 4 (program error) and status bit 1 (lock error).
- R5: Programming 0xFFFD to the lock word clears lock bit 1. After that, programs to the user segment or the lock word leave the data unchanged and set status bits 4 and 1.
- R6: While `prog_volt_low` is high at the data write, the program leaves the data unchanged, sets status bit 3 and does not set bits 4 or 1.
- R7: A program to an address outside 0x80..0x88 writes nothing and sets only status bit 4.
- R8: The write 0x0050 clears status bits 4, 3 and 1. The write 0x0070 selects status read. The write 0x00FF selects array read. A program sequence switches the port to status read. Status read returns {8'h00, status}.
- R9: An idle-state write of any other value changes neither the read mode nor the status.
- R10: Error bits are sticky. A later refused program adds its own bits to those already set, and only 0x0050 removes them.
- R11: In array read mode, an address outside the array reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also array initialisation |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 16 | Command or program data |
| prog_volt_low | input | 1 | Programming voltage below the safe level |
| rd_addr | input | 8 | Word address for array read |
| rd_data | output | 16 | Array word or status byte |
| ready | output | 1 | High when no program is in progress |

## Verification
A wrong lock bit or segment boundary shows up at the next refused or accepted program. The status byte is visible once `ready` returns, `PROG_CYCLES` cycles after the data write, and an array read in the following cycle shows whether the word changed. A busy counter that is wrong by one changes the length of the `ready` low window, and the bench measures that length directly. A sticky flag that drops, or a mode flag that moves on an ignored write, shows on the very next read of the port.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OTP_DW = 16;
  localparam int OTP_AW = 8;

  localparam logic [OTP_DW-1:0] CMD_PROG_SETUP = 16'h00C0;
  localparam logic [OTP_DW-1:0] CMD_CLR_STATUS = 16'h0050;
  localparam logic [OTP_DW-1:0] CMD_RD_STATUS  = 16'h0070;
  localparam logic [OTP_DW-1:0] CMD_RD_ARRAY   = 16'h00FF;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SETUP, SEQ_BUSY} seq_state_e;
  typedef enum logic [1:0] {RES_OK, RES_VOLT, RES_RANGE, RES_LOCK} prog_res_e;

  // Initial contents: lock word, factory words (seed mixed with a
  // nibble-replicated index), user words erased.
  function automatic logic [OTP_DW-1:0] init_word(input int idx, input int seg,
                                                  input logic [OTP_DW-1:0] seed);
    logic [3:0] j;
    if (idx == 0) return 16'hFFFE;
    if (idx <= seg) begin
      j = 4'(idx - 1);
      return seed ^ {j, j, j, j};
    end
    return '1;
  endfunction

  // Decides the outcome of a program attempt. Voltage wins, then range, then lock.
  function automatic prog_res_e judge(input logic [OTP_AW-1:0] addr, input int base,
                                      input int seg, input logic vlow,
                                      input logic [1:0] lk);
    int off;
    off = int'(addr) - base;
    if (vlow) return RES_VOLT;
    if (off < 0 || off > 2 * seg) return RES_RANGE;
    if (off == 0) return lk[1] ? RES_OK : RES_LOCK;
    if (off <= seg) return lk[0] ? RES_OK : RES_LOCK;
    return lk[1] ? RES_OK : RES_LOCK;
  endfunction

  function automatic logic in_array(input logic [OTP_AW-1:0] addr, input int base,
                                    input int seg);
    return (int'(addr) >= base) && (int'(addr) <= base + 2 * seg);
  endfunction
endpackage

// File: rtl/otp_seq.sv
module otp_seq import otp_pkg::*; #(
  parameter int PROG_CYCLES = 4,
  parameter int SEG_WORDS   = 4,
  parameter int BASE_ADDR   = 'h80,
  parameter int IW          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OTP_AW-1:0] wr_addr,
  input  logic [OTP_DW-1:0] wr_data,
  input  logic              prog_volt_low,
  input  logic [1:0]        lock_bits,
  output logic              commit_we,
  output logic [IW-1:0]     commit_idx,
  output logic [OTP_DW-1:0] commit_data,
  output logic [7:0]        status,
  output logic              show_status,
  output logic              clear_evt,
  output logic              ready
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  seq_state_e        st;
  logic [CW-1:0]     cnt;
  prog_res_e         pend_res;
  logic [IW-1:0]     pend_idx;
  logic [OTP_DW-1:0] pend_data;
  logic              err_prog, err_volt, err_lock;
  logic              done_evt;

  assign clear_evt   = (st == SEQ_IDLE) && wr_en && (wr_data == CMD_CLR_STATUS);
  assign done_evt    = (st == SEQ_BUSY) && (cnt == '0);
  assign commit_we   = done_evt && (pend_res == RES_OK);
  assign commit_idx  = pend_idx;
  assign commit_data = pend_data;
  assign ready       = (st != SEQ_BUSY);
  assign status      = {ready, 2'b00, err_prog, err_volt, 1'b0, err_lock, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SEQ_IDLE;
      cnt         <= '0;
      pend_res    <= RES_OK;
      pend_idx    <= '0;
      pend_data   <= '1;
      err_prog    <= 1'b0;
      err_volt    <= 1'b0;
      err_lock    <= 1'b0;
      show_status <= 1'b0;
    end else begin
      case (st)
        SEQ_IDLE: begin
          if (clear_evt) begin
            err_prog <= 1'b0;
            err_volt <= 1'b0;
            err_lock <= 1'b0;
          end else if (wr_en) begin
            case (wr_data)
              CMD_PROG_SETUP: st <= SEQ_SETUP;
              CMD_RD_STATUS:  show_status <= 1'b1;
              CMD_RD_ARRAY:   show_status <= 1'b0;
              default: ;
            endcase
          end
        end
        SEQ_SETUP: begin
          if (wr_en) begin
            pend_res    <= judge(wr_addr, BASE_ADDR, SEG_WORDS, prog_volt_low, lock_bits);
            pend_idx    <= IW'(wr_addr - OTP_AW'(BASE_ADDR));
            pend_data   <= wr_data;
            cnt         <= CW'(PROG_CYCLES - 1);
            show_status <= 1'b1;
            st          <= SEQ_BUSY;
          end
        end
        SEQ_BUSY: begin
          if (done_evt) begin
            st <= SEQ_IDLE;
            case (pend_res)
              RES_VOLT:  err_volt <= 1'b1;
              RES_RANGE: err_prog <= 1'b1;
              RES_LOCK: begin
                err_prog <= 1'b1;
                err_lock <= 1'b1;
              end
              default: ;
            endcase
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_store.sv
module otp_store import otp_pkg::*; #(
  parameter int              SEG_WORDS    = 4,
  parameter logic [OTP_DW-1:0] FACTORY_SEED = 16'h3A5C,
  parameter int              NW           = 9,
  parameter int              IW           = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            idx,
  input  logic [OTP_DW-1:0]        data,
  output logic [NW-1:0][OTP_DW-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= init_word(g, SEG_WORDS, FACTORY_SEED);
      else if (we && (int'(idx) == g)) words[g] <= words[g] & data;
    end
  end
endmodule

// File: rtl/otp_rdmux.sv
module otp_rdmux import otp_pkg::*; #(
  parameter int SEG_WORDS = 4,
  parameter int BASE_ADDR = 'h80,
  parameter int NW        = 9,
  parameter int IW        = 4
) (
  input  logic [OTP_AW-1:0]         rd_addr,
  input  logic                      show_status,
  input  logic [7:0]                status,
  input  logic [NW-1:0][OTP_DW-1:0] words,
  output logic [OTP_DW-1:0]         rd_data
);
  logic [IW-1:0] ridx;
  logic          hit;

  assign ridx = IW'(rd_addr - OTP_AW'(BASE_ADDR));
  assign hit  = in_array(rd_addr, BASE_ADDR, SEG_WORDS);

  always_comb begin
    if (show_status)  rd_data = {{(OTP_DW-8){1'b0}}, status};
    else if (hit)     rd_data = words[ridx];
    else              rd_data = '1;
  end
endmodule

// File: rtl/otp_word_ctrl.sv
module otp_word_ctrl import otp_pkg::*; #(
  parameter int                PROG_CYCLES  = 4,
  parameter int                SEG_WORDS    = 4,
  parameter int                BASE_ADDR    = 'h80,
  parameter logic [OTP_DW-1:0] FACTORY_SEED = 16'h3A5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OTP_AW-1:0] wr_addr,
  input  logic [OTP_DW-1:0] wr_data,
  input  logic              prog_volt_low,
  input  logic [OTP_AW-1:0] rd_addr,
  output logic [OTP_DW-1:0] rd_data,
  output logic              ready
);
  localparam int NW = 1 + 2 * SEG_WORDS;
  localparam int IW = $clog2(NW);

  logic [NW-1:0][OTP_DW-1:0] words;
  logic                      commit_we;
  logic [IW-1:0]             commit_idx;
  logic [OTP_DW-1:0]         commit_data;
  logic [7:0]                status;
  logic                      show_status;
  logic                      clear_evt;
  logic [1:0]                lock_bits;

  assign lock_bits = words[0][1:0];

  otp_seq #(.PROG_CYCLES(PROG_CYCLES), .SEG_WORDS(SEG_WORDS),
            .BASE_ADDR(BASE_ADDR), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_volt_low(prog_volt_low), .lock_bits(lock_bits),
    .commit_we(commit_we), .commit_idx(commit_idx), .commit_data(commit_data),
    .status(status), .show_status(show_status), .clear_evt(clear_evt),
    .ready(ready)
  );

  otp_store #(.SEG_WORDS(SEG_WORDS), .FACTORY_SEED(FACTORY_SEED),
              .NW(NW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .idx(commit_idx),
    .data(commit_data), .words(words)
  );

  otp_rdmux #(.SEG_WORDS(SEG_WORDS), .BASE_ADDR(BASE_ADDR),
              .NW(NW), .IW(IW)) u_rd (
    .rd_addr(rd_addr), .show_status(show_status), .status(status),
    .words(words), .rd_data(rd_data)
  );
endmodule

// File: rtl/otp_word_ctrl_chk.sv
module otp_word_ctrl_chk #(
  parameter int PROG_CYCLES = 4,
  parameter int SEG_WORDS   = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic                             ready,
  input logic                             clear_evt,
  input logic                             commit_we,
  input logic [7:0]                       status,
  input logic [(1+2*SEG_WORDS)*16-1:0]    words_flat
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= '0;
    else if (!ready) low_run <= low_run + 1;
    else            low_run <= '0;
  end

  // R2: stored bits only ever go from 1 to 0
  p_bits_only_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (words_flat & ~$past(words_flat)) == '0);

  // R3: busy window never exceeds the programmed length
  p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= PROG_CYCLES);

  // R3: busy only starts from a bus write
  p_busy_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_en));

  // R3: status bit 7 tracks the ready pin
  p_ready_in_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == ready);

  // R5: lock bits, once cleared, stay cleared
  p_lock_user_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !words_flat[1] |=> !words_flat[1]);
  p_lock_fact_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !words_flat[0] |=> !words_flat[0]);

  // R4: the factory segment never changes while bit 0 is clear
  p_factory_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !words_flat[0] |=> $stable(words_flat[16*(SEG_WORDS+1)-1:16]));

  // R10: error flags are sticky until the clear command
  p_prog_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clear_evt) |=> status[4]);
  p_volt_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !clear_evt) |=> status[3]);

  // R8: the clear command empties all error flags
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (status[4:1] == 4'b0000));

  // R3: no data commit while idle-ready outside a busy window end
  p_commit_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> !ready);
endmodule

bind otp_word_ctrl otp_word_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES), .SEG_WORDS(SEG_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ready(ready),
  .clear_evt(clear_evt), .commit_we(commit_we), .status(status),
  .words_flat(words)
);

// File: tb/tb_otp_word_ctrl.sv
module tb_otp_word_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 4;
  localparam logic [15:0] SEED = 16'h3A5C;

  logic clk = 0, rst_n = 0, wr_en = 0, vlow = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic ready;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_word_ctrl #(.PROG_CYCLES(PCYC), .FACTORY_SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_volt_low(vlow), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_arr(input logic [7:0] a, output logic [15:0] d);
    bus_wr(8'h00, 16'h00FF);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic read_sr(output logic [15:0] d);
    bus_wr(8'h00, 16'h0070);
    #1 d = rd_data;
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] d, input logic v,
                      input logic [15:0] exp_sr, input string req);
    int n = 0;
    bus_wr(8'h00, 16'h00C0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; vlow = v;
    @(negedge clk);
    wr_en = 0; vlow = 0;
    while (!ready && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk({req, " R3 busy length"}, 16'(n), 16'(PCYC));
    #1 chk({req, " status after program R8"}, rd_data, exp_sr);
  endtask

  function automatic logic [15:0] fact_exp(input int j);
    return SEED ^ 16'(j * 16'h1111);
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 ready", 16'(ready), 16'h1);
    rd_addr = 8'h80; #1 chk("R1 lock word", rd_data, 16'hFFFE);
    for (int j = 0; j < 4; j++) begin
      rd_addr = 8'(8'h81 + j); #1 chk("R1 factory word", rd_data, fact_exp(j));
    end
    rd_addr = 8'h88; #1 chk("R1 user word", rd_data, 16'hFFFF);
    read_sr(d); chk("R1 status", d, 16'h0080);
  endtask

  task automatic t_program;
    logic [15:0] d;
    prog(8'h85, 16'hF0F0, 0, 16'h0080, "R2");
    read_arr(8'h85, d); chk("R2 first program", d, 16'hF0F0);
    prog(8'h85, 16'hFF0F, 0, 16'h0080, "R2");
    read_arr(8'h85, d); chk("R2 AND merge", d, 16'hF000);
    prog(8'h85, 16'hFFFF, 0, 16'h0080, "R2");
    read_arr(8'h85, d); chk("R2 no 0 to 1", d, 16'hF000);
  endtask

  task automatic t_factory;
    logic [15:0] d;
    prog(8'h82, 16'h0000, 0, 16'h0092, "R4");
    read_arr(8'h82, d); chk("R4 factory unchanged", d, fact_exp(1));
    bus_wr(8'h00, 16'h0050);
    read_sr(d); chk("R8 clear status", d, 16'h0080);
  endtask

  task automatic t_volt_range;
    logic [15:0] d;
    prog(8'h86, 16'h0000, 1, 16'h0088, "R6");
    read_arr(8'h86, d); chk("R6 data unchanged", d, 16'hFFFF);
    prog(8'h7F, 16'h0000, 0, 16'h0098, "R10");
    read_arr(8'h7F, d); chk("R11 outside reads ones", d, 16'hFFFF);
    bus_wr(8'h00, 16'h0050);
    prog(8'h89, 16'h0000, 0, 16'h0090, "R7");
    read_arr(8'h88, d); chk("R7 neighbour unchanged", d, 16'hFFFF);
    bus_wr(8'h00, 16'h0050);
  endtask

  task automatic t_unknown;
    logic [15:0] d;
    read_arr(8'h85, d);
    bus_wr(8'h00, 16'h0012);
    #1 chk("R9 mode kept array", rd_data, 16'hF000);
    prog(8'h70, 16'h0, 0, 16'h0090, "R7");
    bus_wr(8'h00, 16'h00AB);
    #1 chk("R9 status kept", rd_data, 16'h0090);
    bus_wr(8'h00, 16'h0050);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d;
    bus_wr(8'h00, 16'h00C0);
    bus_wr(8'h87, 16'h00FF);
    chk("R3 ready low", 16'(ready), 16'h0);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'h87; wr_data = 16'h00FF;
    @(negedge clk);
    wr_en = 0;
    while (!ready) @(negedge clk);
    #1 chk("R3 write during busy ignored", rd_data, 16'h0080);
    read_arr(8'h87, d); chk("R3 data from sequence only", d, 16'h00FF);
  endtask

  task automatic t_lock;
    logic [15:0] d;
    prog(8'h80, 16'hFFFD, 0, 16'h0080, "R5");
    read_arr(8'h80, d); chk("R5 lock word", d, 16'hFFFC);
    prog(8'h86, 16'h0000, 0, 16'h0092, "R5");
    read_arr(8'h86, d); chk("R5 user frozen", d, 16'hFFFF);
    bus_wr(8'h00, 16'h0050);
    prog(8'h80, 16'h0000, 0, 16'h0092, "R5");
    read_arr(8'h80, d); chk("R5 lock word frozen", d, 16'hFFFC);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_factory();
    t_volt_range();
    t_unknown();
    t_busy_ignore();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule